// File: doc/BRIEF.md
# SD Card Line Power Controller

This block owns the card-facing pins of an SD/MMC host: the command line, a bank of data lines and the card clock line. Software selects a power mode by writing a 2-bit mode field through a single-cycle write port. The field can be read back at any time. Each mode drives every line into a defined electrical state: tri-stated, driven high or driven low. A power-on mode first runs the card clock for a fixed number of initialization cycles and then passes the lines to the host datapath.

Two different line states share the mode code 00. After a hardware reset the lines float and the clock is held low. After a software write of 00 every line is driven high. Once power-on has been written, the mode is locked: only a hardware reset can leave it. The card clock is produced inside the block. It toggles on each pulse of an externally supplied tick strobe, and the initialization count is a count of its rising edges.

A typical bring-up writes 10 to pull every line low while the supply ramps, then writes 00 to raise the lines, then writes 11 to start the card. Writing 11 directly from any state is also accepted.

Top module: `sdline_pwr_ctrl`

## Requirements
- R1: After hardware reset the mode field reads 00, the command and data outputs are tri-stated (enables 0), the clock line is driven low (ck_oe=1, ck_o=0), host_en and init_done are 0, and tick pulses leave ck_o at 0.
- R2: A write of 00 outside power-on drives the command, data and clock lines high (all enables 1, all values 1), the field reads 00, and the clock does not toggle on ticks.
- R3: A write of 10 outside power-on drives the command, data and clock lines low (all enables 1, all values 0), and the field reads 10.
- R4: A write of 01 is reserved: the field and every line output keep their previous values.
- R5: A write of 11 is accepted from the reset, high or low state. Afterwards the field reads 11, host_en is 0, the command and data lines are driven high, and ck_o inverts on every cycle in which ck_tick is 1, starting from 0.
- R6: host_en and init_done become 1 right after the 74th rising edge of ck_o in power-on (the 147th tick) and not before; both then stay 1 until reset.
- R7: While host_en is 1, the command and data enables and values equal the host_* inputs, and the clock line keeps carrying the toggling card clock.
- R8: While the field reads 11, writes of any code are ignored: the field stays 11 and the line outputs are unaffected.
- R9: host_en is 0 in every state other than power-on with the count complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Mode field write strobe |
| wr_data | input | 2 | Mode code written (00 off, 01 reserved, 10 cycle, 11 on) |
| mode_rd | output | 2 | Current mode field value |
| ck_tick | input | 1 | One pulse per card clock half period |
| host_cmd_oe | input | 1 | Datapath command output enable |
| host_cmd_o | input | 1 | Datapath command output value |
| host_dat_oe | input | DATA_W | Datapath data output enables |
| host_dat_o | input | DATA_W | Datapath data output values |
| host_en | output | 1 | Host datapath owns the lines |
| init_done | output | 1 | Initialization clock count complete |
| cmd_oe | output | 1 | Command pin output enable |
| cmd_o | output | 1 | Command pin value |
| dat_oe | output | DATA_W | Data pin output enables |
| dat_o | output | DATA_W | Data pin values |
| ck_oe | output | 1 | Clock pin output enable |
| ck_o | output | 1 | Clock pin value |

## Verification
A wrong line state shows up on the pins in the cycle after the write that caused it. The field readback and the drive pattern are both checked after each write, so a reset state confused with the software power-off state cannot hide. An error in the initialization counter appears only at the 147th tick, where host_en rises one tick too early or too late. The bench therefore checks the tick just before and the tick at the boundary. Loss of the power-on lock shows as a change in the field readback one cycle after an ignored write.

// File: rtl/sdline_pwr_pkg.sv
package sdline_pwr_pkg;
  localparam logic [1:0] CODE_OFF   = 2'b00;
  localparam logic [1:0] CODE_RSV   = 2'b01;
  localparam logic [1:0] CODE_CYCLE = 2'b10;
  localparam logic [1:0] CODE_ON    = 2'b11;

  // Line state; LS_FLOAT and LS_HIGH both read back as CODE_OFF.
  typedef enum logic [1:0] {
    LS_FLOAT = 2'd0,
    LS_HIGH  = 2'd1,
    LS_LOW   = 2'd2,
    LS_ON    = 2'd3
  } line_state_e;
endpackage

// File: rtl/sdline_mode_reg.sv
module sdline_mode_reg
  import sdline_pwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_data,
  output line_state_e state,
  output logic [1:0]  mode_rd
);
  line_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en && (state_q != LS_ON)) begin
      case (wr_data)
        CODE_OFF:   state_d = LS_HIGH;
        CODE_CYCLE: state_d = LS_LOW;
        CODE_ON:    state_d = LS_ON;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LS_FLOAT;
    else        state_q <= state_d;
  end

  always_comb begin
    case (state_q)
      LS_LOW:  mode_rd = CODE_CYCLE;
      LS_ON:   mode_rd = CODE_ON;
      default: mode_rd = CODE_OFF;
    endcase
  end

  assign state = state_q;
endmodule

// File: rtl/sdline_init_counter.sv
module sdline_init_counter #(
  parameter int INIT_CYCLES = 74
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic ck_level,
  output logic done
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(INIT_CYCLES);

  logic          ck_q, ck_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ck_en, cnt_en;

  assign done   = (cnt_q == LIMIT);
  assign ck_en  = run && tick;
  assign cnt_en = ck_en && !ck_q && !done;

  always_comb begin
    ck_d  = ck_q;
    cnt_d = cnt_q;
    if (ck_en)  ck_d  = !ck_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ck_q  <= ck_d;
      cnt_q <= cnt_d;
    end
  end

  assign ck_level = ck_q;
endmodule

// File: rtl/sdline_pin_mux.sv
module sdline_pin_mux
  import sdline_pwr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  line_state_e       state,
  input  logic              done,
  input  logic              ck_level,
  input  logic              host_cmd_oe,
  input  logic              host_cmd_o,
  input  logic [DATA_W-1:0] host_dat_oe,
  input  logic [DATA_W-1:0] host_dat_o,
  output logic              cmd_oe,
  output logic              cmd_o,
  output logic [DATA_W-1:0] dat_oe,
  output logic [DATA_W-1:0] dat_o,
  output logic              ck_oe,
  output logic              ck_o
);
  logic fix_oe, fix_val, pass;

  always_comb begin
    fix_oe  = 1'b1;
    fix_val = 1'b1;
    ck_oe   = 1'b1;
    ck_o    = 1'b0;
    case (state)
      LS_FLOAT: begin fix_oe = 1'b0; fix_val = 1'b0; ck_o = 1'b0; end
      LS_HIGH:  begin fix_val = 1'b1; ck_o = 1'b1; end
      LS_LOW:   begin fix_val = 1'b0; ck_o = 1'b0; end
      default:  begin fix_val = 1'b1; ck_o = ck_level; end
    endcase
  end

  assign pass   = (state == LS_ON) && done;
  assign cmd_oe = pass ? host_cmd_oe : fix_oe;
  assign cmd_o  = pass ? host_cmd_o  : fix_val;

  for (genvar i = 0; i < DATA_W; i++) begin : g_dat
    assign dat_oe[i] = pass ? host_dat_oe[i] : fix_oe;
    assign dat_o[i]  = pass ? host_dat_o[i]  : fix_val;
  end
endmodule

// File: rtl/sdline_pwr_ctrl.sv
module sdline_pwr_ctrl
  import sdline_pwr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int INIT_CYCLES = 74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_data,
  output logic [1:0]        mode_rd,
  input  logic              ck_tick,
  input  logic              host_cmd_oe,
  input  logic              host_cmd_o,
  input  logic [DATA_W-1:0] host_dat_oe,
  input  logic [DATA_W-1:0] host_dat_o,
  output logic              host_en,
  output logic              init_done,
  output logic              cmd_oe,
  output logic              cmd_o,
  output logic [DATA_W-1:0] dat_oe,
  output logic [DATA_W-1:0] dat_o,
  output logic              ck_oe,
  output logic              ck_o
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  line_state_e state;
  logic        ck_level, cnt_done;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sdline_mode_reg i_mode (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .state   (state),
    .mode_rd (mode_rd)
  );

  sdline_init_counter #(.INIT_CYCLES(INIT_CYCLES)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (state == LS_ON),
    .tick     (ck_tick),
    .ck_level (ck_level),
    .done     (cnt_done)
  );

  sdline_pin_mux #(.DATA_W(DATA_W)) i_mux (
    .state       (state),
    .done        (cnt_done),
    .ck_level    (ck_level),
    .host_cmd_oe (host_cmd_oe),
    .host_cmd_o  (host_cmd_o),
    .host_dat_oe (host_dat_oe),
    .host_dat_o  (host_dat_o),
    .cmd_oe      (cmd_oe),
    .cmd_o       (cmd_o),
    .dat_oe      (dat_oe),
    .dat_o       (dat_o),
    .ck_oe       (ck_oe),
    .ck_o        (ck_o)
  );

  assign init_done = cnt_done && (state == LS_ON);
  assign host_en   = init_done;
endmodule

// File: rtl/sdline_pwr_chk.sv
module sdline_pwr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_data,
  input logic [1:0]        mode_rd,
  input logic              ck_tick,
  input logic              host_en,
  input logic              cmd_o,
  input logic [DATA_W-1:0] dat_oe,
  input logic [DATA_W-1:0] dat_o,
  input logic              ck_o
);
  AST_ON_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rd == 2'b11 |=> mode_rd == 2'b11); // R8

  AST_RSV_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 2'b01) |=> $stable(mode_rd)); // R4

  AST_EN_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |-> mode_rd == 2'b11); // R9

  AST_LOW_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rd == 2'b10 |-> (&dat_oe && dat_o == '0 && !cmd_o && !ck_o)); // R3

  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |=> host_en); // R6

  AST_CK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd == 2'b11 && ck_tick) |=> ck_o != $past(ck_o)); // R5
endmodule

bind sdline_pwr_ctrl sdline_pwr_chk #(.DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .mode_rd (mode_rd),
  .ck_tick (ck_tick),
  .host_en (host_en),
  .cmd_o   (cmd_o),
  .dat_oe  (dat_oe),
  .dat_o   (dat_o),
  .ck_o    (ck_o)
);

// File: tb/test_sdline_pwr_ctrl.sv
module test_sdline_pwr_ctrl;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_data;
  logic [1:0]    mode_rd;
  logic          ck_tick;
  logic          host_cmd_oe, host_cmd_o;
  logic [DW-1:0] host_dat_oe, host_dat_o;
  logic          host_en, init_done, cmd_oe, cmd_o, ck_oe, ck_o;
  logic [DW-1:0] dat_oe, dat_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sdline_pwr_ctrl #(.DATA_W(DW), .INIT_CYCLES(74)) i_sdline_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mode_rd(mode_rd), .ck_tick(ck_tick),
    .host_cmd_oe(host_cmd_oe), .host_cmd_o(host_cmd_o),
    .host_dat_oe(host_dat_oe), .host_dat_o(host_dat_o),
    .host_en(host_en), .init_done(init_done),
    .cmd_oe(cmd_oe), .cmd_o(cmd_o), .dat_oe(dat_oe), .dat_o(dat_o),
    .ck_oe(ck_oe), .ck_o(ck_o)
  );

  // {wr[7:6], field[5:4], line_oe[3], line_val[2], ck_oe[1], ck_o[0]}
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{
    8'b10_10_1_0_1_0,
    8'b01_10_1_0_1_0,
    8'b00_00_1_1_1_1,
    8'b01_00_1_1_1_1,
    8'b10_10_1_0_1_0,
    8'b00_00_1_1_1_1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic write_mode(input logic [1:0] code);
    @(negedge clk); wr_en = 1'b1; wr_data = code;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic one_tick();
    @(negedge clk); ck_tick = 1'b1;
    @(negedge clk); ck_tick = 1'b0;
  endtask

  task automatic lines_fixed(input string tag, input logic oe, input logic v,
                             input logic cko);
    chk(tag, {cmd_oe, cmd_o, dat_oe, dat_o, ck_oe, ck_o},
        {oe, v, {DW{oe}}, {DW{v}}, 1'b1, cko});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 field", {30'd0, mode_rd}, 32'd0);
    lines_fixed("R1 lines", 1'b0, 1'b0, 1'b0);
    chk("R9 host_en in reset", {31'd0, host_en}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 2'b00; ck_tick = 1'b0;
    host_cmd_oe = 1'b0; host_cmd_o = 1'b0; host_dat_oe = '0; host_dat_o = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, clock stays stopped on ticks
    chk("R1 field", {30'd0, mode_rd}, 32'd0);
    lines_fixed("R1 lines", 1'b0, 1'b0, 1'b0);
    chk("R1 init_done", {31'd0, init_done}, 32'd0);
    one_tick();
    chk("R1 clock stopped", {31'd0, ck_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (VEC[i][7:6] == 2'b01) ? "R4" : (VEC[i][7:6] == 2'b00) ? "R2" : "R3";
      write_mode(VEC[i][7:6]);
      chk(tag, {30'd0, mode_rd}, {30'd0, VEC[i][5:4]});
      chk(tag, {cmd_oe, cmd_o, dat_oe, dat_o, ck_oe, ck_o},
          {VEC[i][3], VEC[i][2], {DW{VEC[i][3]}}, {DW{VEC[i][2]}}, VEC[i][1], VEC[i][0]});
      chk("R9", {31'd0, host_en}, 32'd0);
    end

    // R2: ticks do not move the clock in the high state
    one_tick();
    chk("R2 clock held high", {31'd0, ck_o}, 32'd1);

    // R5: power-on from the high state
    write_mode(2'b11);
    chk("R5 field", {30'd0, mode_rd}, 32'd3);
    lines_fixed("R5 lines", 1'b1, 1'b1, 1'b0);
    chk("R5 host_en", {31'd0, host_en}, 32'd0);

    // R8: writes during init are ignored
    write_mode(2'b00);
    chk("R8 field after 00", {30'd0, mode_rd}, 32'd3);
    lines_fixed("R8 lines", 1'b1, 1'b1, 1'b0);

    one_tick();
    chk("R5 ck after tick 1", {31'd0, ck_o}, 32'd1);
    one_tick();
    chk("R5 ck after tick 2", {31'd0, ck_o}, 32'd0);
    for (int t = 2; t < 146; t++) one_tick();
    chk("R6 not done at 146", {30'd0, init_done, host_en}, 32'd0);
    lines_fixed("R6 lines before done", 1'b1, 1'b1, 1'b0);
    one_tick();
    chk("R6 done at 147", {30'd0, init_done, host_en}, 32'd3);

    // R7: pass-through with two patterns
    host_cmd_oe = 1'b1; host_cmd_o = 1'b0; host_dat_oe = 8'hA5; host_dat_o = 8'h3C;
    #1;
    chk("R7 pattern A", {cmd_oe, cmd_o, dat_oe, dat_o, ck_o},
        {1'b1, 1'b0, 8'hA5, 8'h3C, 1'b1});
    host_cmd_oe = 1'b0; host_cmd_o = 1'b1; host_dat_oe = 8'h0F; host_dat_o = 8'hF0;
    #1;
    chk("R7 pattern B", {cmd_oe, cmd_o, dat_oe, dat_o}, {1'b0, 1'b1, 8'h0F, 8'hF0});

    // R8: lock after enable
    write_mode(2'b10);
    chk("R8 field after 10", {30'd0, mode_rd}, 32'd3);
    chk("R8 lines stay host", {cmd_oe, cmd_o, dat_oe, dat_o}, {1'b0, 1'b1, 8'h0F, 8'hF0});
    one_tick();
    chk("R7 clock keeps toggling", {31'd0, ck_o}, 32'd0);
    chk("R6 stays enabled", {31'd0, host_en}, 32'd1);

    // R1/R5: hardware reset leaves power-on, then direct power-on
    do_reset();
    chk("R1 after reset", {30'd0, mode_rd}, 32'd0);
    write_mode(2'b11);
    chk("R5 direct from reset", {30'd0, mode_rd}, 32'd3);
    chk("R9 host_en during init", {31'd0, host_en}, 32'd0);

    finish_run();
  end
endmodule